// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight dedicated external interrupt pins and turns their activity into per-pin interrupt requests. Each pin is given its own sense mode: a held-low level, a falling edge, a rising edge, or either edge. Edge events are caught in a per-pin flag that software clears by writing a one to it, or that the interrupt dispatcher clears with a per-pin acknowledge strobe. A low level is not latched. The request follows the pin for as long as it stays low. A pin triggers whatever its pad direction is, so firmware can raise an interrupt by driving the pin itself.

The block runs on an always-on sampling clock. The I/O clock is represented by a run indication, `io_clk_en`. Pins 0-3 keep detecting edges while the I/O clock is gated. Pins 4-7 recognise edges only while it runs. Every pin passes through a two-flop synchronizer before it can set a flag. A separate combinational wake output is taken straight from the raw pins, so a low level on any enabled pin, or a qualifying edge on pins 0-3, can start a wake-up before the synchronizer has caught up.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all four registers read zero, every interrupt request is low and the wake output is low.
- R2: The sense code for pin n is a 2-bit field at bits [2(n mod 4)+1 : 2(n mod 4)]. Pins 0-3 use address 0 and pins 4-7 use address 1. Address 2 holds the enable mask, with bit n for pin n. Address 3 reads the flags, with bit n for pin n. Addresses 0-2 read back what was last written.
- R3: With sense code 00 (low level), irq_o[n] is high while the enable bit is set and the pin is low, starting two clocks after the pin falls. It drops two clocks after the pin rises, and no flag is set.
- R4: With sense code 10 (falling edge), a high-to-low transition sets flag n within three clocks, and a rising transition sets nothing.
- R5: With sense code 11 (rising edge), a low-to-high transition sets flag n, and a falling transition sets nothing.
- R6: With sense code 01 (any edge), both transitions set flag n.
- R7: Writing address 3 clears each flag whose write-data bit is 1. A 0 bit leaves its flag unchanged.
- R8: A one-cycle pulse on ack_i[n] clears flag n.
- R9: When a new edge event and a clear (write or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R10: While io_clk_en is low, edges on pins 4-7 set no flag. Edges on pins 0-3 still do.
- R11: For edge modes, irq_o[n] equals flag n ANDed with enable bit n. A flag is latched even while its pin is disabled, and irq_o[n] rises once the pin is enabled.
- R12: wake_o is high whenever any irq_o bit is high. It also rises combinationally, with no clock, when an enabled level-mode pin is low, or when an enabled edge-mode pin 0-3 shows a qualifying transition that has not yet passed the synchronizer. Edge-mode pins 4-7 give no early wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_clk_en | input | 1 | High while the I/O clock runs |
| pins_i | input | 8 | External interrupt pins, raw |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 sense lo, 1 sense hi, 2 enable, 3 flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| ack_i | input | 8 | Per-pin flag acknowledge strobes |
| irq_o | output | 8 | Per-pin interrupt requests |
| wake_o | output | 1 | Combined wake request |

## Verification
The two functions that can land in the same cycle are setting a flag from a synchronized edge and clearing that flag, either by a write-one-to-clear or by an acknowledge pulse. The bench provokes this collision by timing a clear so that it takes effect on exactly the clock edge on which the edge leaves the synchronizer: the pin is driven, two edges are counted, and then the clear is applied for one cycle. It judges the result by reading the flag register, which must still show the bit set. The bench then confirms separately that a clear applied on its own does empty the flag.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_SENSE_LO = 2'd0;
  localparam logic [1:0] ADDR_SENSE_HI = 2'd1;
  localparam logic [1:0] ADDR_ENABLE   = 2'd2;
  localparam logic [1:0] ADDR_FLAGS    = 2'd3;
endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
  parameter int   W       = 8,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= {W{RST_VAL}};
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/eisc_regs.sv
module eisc_regs
  import eisc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [1:0]     addr,
  input  logic [N-1:0]   wdata,
  input  logic [N-1:0]   ack,
  input  logic [N-1:0]   flags,
  output logic [2*N-1:0] sense,
  output logic [N-1:0]   en,
  output logic [N-1:0]   clr,
  output logic [N-1:0]   rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense <= '0;
      en    <= '0;
    end else if (we) begin
      case (addr)
        ADDR_SENSE_LO: sense[N-1:0]   <= wdata;
        ADDR_SENSE_HI: sense[2*N-1:N] <= wdata;
        ADDR_ENABLE:   en             <= wdata;
        default: ;
      endcase
    end
  end

  assign clr = ((we && addr == ADDR_FLAGS) ? wdata : '0) | ack;

  always_comb begin
    case (addr)
      ADDR_SENSE_LO: rdata = sense[N-1:0];
      ADDR_SENSE_HI: rdata = sense[2*N-1:N];
      ADDR_ENABLE:   rdata = en;
      default:       rdata = flags;
    endcase
  end
endmodule

// File: rtl/eisc_pin_detect.sv
module eisc_pin_detect
  import eisc_pkg::*;
#(
  parameter bit ASYNC_EDGE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_clk_en,
  input  logic       pin_raw,
  input  logic       pin_s,
  input  logic [1:0] mode,
  input  logic       enable,
  input  logic       clr,
  output logic       flag,
  output logic       req,
  output logic       wake_cond
);
  logic prev, fall, rise, hit, clk_ok, edge_hit, level_req, raw_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= pin_s;
  end

  assign fall = prev & ~pin_s;
  assign rise = ~prev & pin_s;

  always_comb begin
    case (sense_e'(mode))
      SENSE_ANY:  hit = fall | rise;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  // Pins without asynchronous edge capture depend on the I/O clock running.
  assign clk_ok   = ASYNC_EDGE ? 1'b1 : io_clk_en;
  assign edge_hit = hit & clk_ok;

  // A new event has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (edge_hit) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  assign level_req = (mode == SENSE_LOW) & ~pin_s;
  assign req       = enable & ((mode == SENSE_LOW) ? level_req : flag);

  always_comb begin
    case (sense_e'(mode))
      SENSE_ANY:  raw_edge = pin_raw ^ pin_s;
      SENSE_FALL: raw_edge = pin_s & ~pin_raw;
      SENSE_RISE: raw_edge = ~pin_s & pin_raw;
      default:    raw_edge = 1'b0;
    endcase
  end

  assign wake_cond = enable & (((mode == SENSE_LOW) & ~pin_raw) | (ASYNC_EDGE & raw_edge));

  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(edge_hit));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(edge_hit) |-> flag);

  assert_level_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LOW) |=> !$rose(flag));

  generate
    if (!ASYNC_EDGE) begin : g_gated_chk
      assert_gated_no_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(io_clk_en));
    end
  endgenerate
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eisc_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int N_ASYNC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_clk_en,
  input  logic [N_PINS-1:0] pins_i,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [N_PINS-1:0] reg_wdata,
  output logic [N_PINS-1:0] reg_rdata,
  input  logic [N_PINS-1:0] ack_i,
  output logic [N_PINS-1:0] irq_o,
  output logic              wake_o
);
  logic [N_PINS-1:0]   pins_s, flags, clr, en, wake_cond;
  logic [2*N_PINS-1:0] sense;

  eisc_sync #(.W(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_i), .q(pins_s)
  );

  eisc_regs #(.N(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ack(ack_i), .flags(flags), .sense(sense), .en(en), .clr(clr), .rdata(reg_rdata)
  );

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      eisc_pin_detect #(.ASYNC_EDGE(i < N_ASYNC)) u_det (
        .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en),
        .pin_raw(pins_i[i]), .pin_s(pins_s[i]), .mode(sense[2*i+1:2*i]),
        .enable(en[i]), .clr(clr[i]), .flag(flags[i]), .req(irq_o[i]),
        .wake_cond(wake_cond[i])
      );
    end
  endgenerate

  assign wake_o = (|wake_cond) | (|irq_o);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~en) == '0);

  assert_wake_on_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> wake_o);
endmodule

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_clk_en = 1'b1;
  logic [7:0] pins_i = 8'hFF;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] ack_i = 8'h00;
  logic [7:0] irq_o;
  logic       wake_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ext_irq_sense dut (
    .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .pins_i(pins_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_i(ack_i), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    logic [7:0]  rv;
    logic [15:0] sv;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv);
      chk("R1 reg reset", rv, 0);
    end
    chk("R1 irq reset", irq_o, 0);
    chk("R1 wake reset", wake_o, 0);

    // R2 register mapping and readback
    wr(2'd0, 8'hE4); wr(2'd1, 8'h1B); wr(2'd2, 8'hA5);
    rd(2'd0, rv); chk("R2 sense lo", rv, 8'hE4);
    rd(2'd1, rv); chk("R2 sense hi", rv, 8'h1B);
    rd(2'd2, rv); chk("R2 enable", rv, 8'hA5);
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    step(3);

    // Sweep: every pin x every sense code x I/O clock on/off
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int io = 1; io >= 0; io--) begin
          int ef, ei, ew;
          string tf;
          sv = 16'h0000;
          sv[2*p +: 2] = m[1:0];
          wr(2'd0, sv[7:0]); wr(2'd1, sv[15:8]);
          wr(2'd2, 8'(1 << p));
          wr(2'd3, 8'hFF);
          io_clk_en = io[0];
          step(3);
          tf = (p >= 4 && io == 0) ? "R10" : (m == 0) ? "R3" : (m == 1) ? "R6" : (m == 2) ? "R4" : "R5";

          // falling transition
          pins_i[p] = 1'b0;
          #1;
          ew = (m == 0) ? 1 : ((p < 4 && (m == 1 || m == 2)) ? 1 : 0);
          chk("R12 wake on fall", wake_o, ew);
          step(4);
          ef = ((m == 1 || m == 2) && (p < 4 || io == 1)) ? 1 : 0;
          ei = (m == 0) ? 1 : ef;
          rd(2'd3, rv);
          chk({tf, " flag after fall"}, rv[p], ef);
          chk({tf, " irq after fall"}, irq_o[p], ei);
          wr(2'd3, 8'hFF);
          step(1);

          // rising transition
          pins_i[p] = 1'b1;
          #1;
          ew = (m == 0) ? 1 : ((p < 4 && (m == 1 || m == 3)) ? 1 : 0);
          chk("R12 wake on rise", wake_o, ew);
          step(4);
          ef = ((m == 1 || m == 3) && (p < 4 || io == 1)) ? 1 : 0;
          ei = (m == 0) ? 0 : ef;
          rd(2'd3, rv);
          chk({tf, " flag after rise"}, rv[p], ef);
          chk({tf, " irq after rise"}, irq_o[p], ei);
          chk("R12 wake follows irq", wake_o, ei);
          wr(2'd3, 8'hFF);
          step(1);
        end
      end
    end
    io_clk_en = 1'b1;

    // R9 / R7 / R8 on pin 1, any-edge
    wr(2'd0, 8'h04); wr(2'd1, 8'h00); wr(2'd2, 8'h02); wr(2'd3, 8'hFF);
    step(2);
    pins_i[1] = 1'b0;
    step(4);
    rd(2'd3, rv); chk("R6 flag set before collision", rv[1], 1);
    pins_i[1] = 1'b1;
    step(2);
    wr(2'd3, 8'h02);               // clear lands on the set cycle
    rd(2'd3, rv); chk("R9 set beats write clear", rv[1], 1);
    wr(2'd3, 8'h00);
    rd(2'd3, rv); chk("R7 zero write keeps flag", rv[1], 1);
    wr(2'd3, 8'h02);
    rd(2'd3, rv); chk("R7 one write clears flag", rv[1], 0);
    pins_i[1] = 1'b0;
    step(2);
    ack_i = 8'h02; step(1); ack_i = 8'h00;
    rd(2'd3, rv); chk("R9 set beats ack", rv[1], 1);
    ack_i = 8'h02; step(1); ack_i = 8'h00;
    rd(2'd3, rv); chk("R8 ack clears flag", rv[1], 0);
    chk("R8 irq low after ack", irq_o[1], 0);
    pins_i[1] = 1'b1;
    step(4);
    wr(2'd3, 8'hFF);

    // R11 flag latched while disabled
    wr(2'd0, 8'h20); wr(2'd2, 8'h00);
    step(2);
    pins_i[2] = 1'b0;
    step(4);
    rd(2'd3, rv); chk("R11 flag while disabled", rv[2], 1);
    chk("R11 irq masked", irq_o[2], 0);
    wr(2'd2, 8'h04);
    chk("R11 irq after enable", irq_o[2], 1);
    chk("R12 wake with irq", wake_o, 1);

    step(2);
    summary();
  end
endmodule